// File: doc/BRIEF.md
# Four-Channel Shared-Bus Copy Engine

This block copies byte streams from one address range to another on a system bus that it shares with a CPU. Each of its four channels holds a source pointer, a destination pointer and a 24-bit remaining byte count. Software sets these through a narrow write-only configuration port. A channel is started by setting its enable bit. When all its bytes have moved, the channel raises a sticky completion flag.

Every byte takes two bus cycles. The first reads the source address on a single-cycle memory port. The second writes the returned byte to the destination address. A static mode input sets how the engine obtains the bus:
- In burst mode it requests the bus through a hold request/acknowledge handshake with the CPU. It then moves up to 32 bytes while the CPU waits, and hands the bus back.
- In stealing mode it takes the bus for exactly one byte per acknowledge.
- In transparent mode it never asks for the bus. It uses only those cycles in which the CPU reports that it is not driving the bus.

Each channel also has two flow-control inputs: source data available and destination space available. A channel is only started when both are high. A burst run is cut short when either one falls.

Top module: `mdma_engine`

## Requirements
- R1: Each byte moved is a read at the channel's source address followed by a write of that byte at its destination address. Both addresses then advance by one and the count drops by one, so after N bytes the destination range equals the source range.
- R2: When a channel's count reaches zero, its enable clears and its done bit sets. The done bit stays set until a control write with bit 1 set. The finished channel makes no further bus requests.
- R3: A control write that sets enable while the channel's count is zero sets done at that clock edge. It never raises the hold request.
- R4: In burst mode one hold request/acknowledge period carries at most 32 byte writes. The hold request then falls. A 40-byte transfer with flow control always open therefore uses exactly two grants, of 32 and 8 bytes.
- R5: In burst mode, if the active channel's source-available or destination-space input is low after a write, the run ends and the bus is released. The remaining bytes are moved in later runs with no loss or duplication.
- R6: In stealing mode each hold request/acknowledge period carries exactly one byte write.
- R7: In transparent mode the hold request is never raised, and the memory port is enabled only in cycles where `cpu_idle` is high.
- R8: When several channels are ready at the same time, the lowest-numbered channel is served first.
- R9: In burst and stealing modes the memory port is enabled only while `hold_ack` is high.
- R10: Configuration field codes on `cfg_field` are 0 = source address, 1 = destination address, 2 = byte count, 3 = control. In the control field, bit 0 is enable and bit 1 clears done. Writing control with bit 0 low disables the channel.
- R11: Mode codes on `xfer_mode` are 0 = burst, 1 = stealing, 2 = transparent; code 3 acts as burst. The mode is sampled when the engine selects a channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_chan | input | 2 | Channel selected by the write |
| cfg_field | input | 2 | Field selected by the write |
| cfg_wdata | input | 24 | Configuration write data |
| xfer_mode | input | 2 | Bus access mode |
| hold_req | output | 1 | Bus request to the CPU |
| hold_ack | input | 1 | CPU grants the bus |
| cpu_idle | input | 1 | CPU is not using the bus this cycle |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write (else read) |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read |
| src_avail | input | 4 | Per-channel source data available |
| dst_space | input | 4 | Per-channel destination space available |
| done | output | 4 | Per-channel sticky completion flag |

## Verification
Some rules hold at every cycle, and assertions check them continuously:
- In transparent mode the engine never touches the bus while the CPU is active.
- In burst and stealing modes it never touches the bus without an acknowledge.
- A stealing grant ends after one write.
- A burst run never exceeds 32 bytes.
- Done is sticky.
- A byte step happens only on an enabled channel with bytes left.

Other behaviour shows up only in whole scenarios: that copied data is correct and complete, exact grant counts for a given length, lowest-index-first ordering, and correct resumption after flow control interrupts a burst. The bench covers these with random lengths, modes and CPU idle patterns, plus directed cases.

// File: rtl/mdma_pkg.sv
`timescale 1ns/1ps
package mdma_pkg;

    typedef enum logic [1:0] {
        MODE_BURST = 2'd0,
        MODE_STEAL = 2'd1,
        MODE_TRANS = 2'd2
    } xfer_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_RD,
        ST_WR,
        ST_REL
    } mv_state_e;

    localparam logic [1:0] FLD_SRC  = 2'd0;
    localparam logic [1:0] FLD_DST  = 2'd1;
    localparam logic [1:0] FLD_CNT  = 2'd2;
    localparam logic [1:0] FLD_CTRL = 2'd3;

endpackage

// File: rtl/mdma_chan.sv
`timescale 1ns/1ps
module mdma_chan
    import mdma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 24,
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_field,
    input  logic [DW-1:0] wr_data,
    input  logic          step,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] dst_addr,
    output logic [CW-1:0] count,
    output logic          pending,
    output logic          done
);

    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] cnt;
        logic          en;
        logic          fin;
    } chan_s;

    chan_s q, d;

    always_comb begin
        d = q;
        if (wr_en) begin
            case (wr_field)
                FLD_SRC: d.src = wr_data[AW-1:0];
                FLD_DST: d.dst = wr_data[AW-1:0];
                FLD_CNT: d.cnt = wr_data[CW-1:0];
                default: begin
                    if (wr_data[1]) d.fin = 1'b0;
                    if (wr_data[0]) begin
                        if (q.cnt == '0) d.fin = 1'b1;
                        else             d.en  = 1'b1;
                    end else begin
                        d.en = 1'b0;
                    end
                end
            endcase
        end
        if (step) begin
            d.src = q.src + 1'b1;
            d.dst = q.dst + 1'b1;
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CW'(1)) begin
                d.en  = 1'b0;
                d.fin = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign src_addr = q.src;
    assign dst_addr = q.dst;
    assign count    = q.cnt;
    assign pending  = q.en && (q.cnt != '0);
    assign done     = q.fin;

    AST_STEP_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (q.en && q.cnt != '0)) else $error("step on idle channel"); // R1

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.fin && !(wr_en && wr_field == FLD_CTRL && wr_data[1])) |=> q.fin) else $error("done lost"); // R2

    AST_ZERO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_field == FLD_CTRL && wr_data[0] && !wr_data[1] && q.cnt == '0 && !step)
        |=> (q.fin && !q.en)) else $error("zero count start"); // R3

endmodule

// File: rtl/mdma_prio.sv
`timescale 1ns/1ps
module mdma_prio #(
    parameter  int N  = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/mdma_mover.sv
`timescale 1ns/1ps
module mdma_mover
    import mdma_pkg::*;
#(
    parameter  int NCH     = 4,
    parameter  int AW      = 16,
    parameter  int RUN_MAX = 32,
    localparam int CHW     = $clog2(NCH),
    localparam int RW      = $clog2(RUN_MAX + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  xfer_mode_e     mode_i,
    input  logic           cand_any,
    input  logic [CHW-1:0] cand_idx,
    input  logic [AW-1:0]  src_sel,
    input  logic [AW-1:0]  dst_sel,
    input  logic           last_sel,
    input  logic           avail_sel,
    input  logic           hold_ack,
    input  logic           cpu_idle,
    input  logic [7:0]     mem_rdata,
    output logic           hold_req,
    output logic           mem_en,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [7:0]     mem_wdata,
    output logic           step,
    output logic [CHW-1:0] cur_ch
);

    localparam logic [RW-1:0] RUN_LAST = RW'(RUN_MAX - 1);

    typedef struct packed {
        mv_state_e      st;
        logic [CHW-1:0] ch;
        xfer_mode_e     mode;
        logic [RW-1:0]  run;
        logic [7:0]     data;
        logic           have;
    } mv_s;

    mv_s q, d;

    always_comb begin
        d         = q;
        hold_req  = 1'b0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = src_sel;
        mem_wdata = q.have ? q.data : mem_rdata;
        step      = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (cand_any) begin
                    d.ch   = cand_idx;
                    d.mode = mode_i;
                    d.run  = '0;
                    d.have = 1'b0;
                    d.st   = (mode_i == MODE_TRANS) ? ST_RD : ST_REQ;
                end
            end
            ST_REQ: begin
                hold_req = 1'b1;
                if (hold_ack) d.st = avail_sel ? ST_RD : ST_REL;
            end
            ST_RD: begin
                mem_addr = src_sel;
                if (q.mode == MODE_TRANS) begin
                    if (cpu_idle) begin
                        mem_en = 1'b1;
                        d.have = 1'b0;
                        d.st   = ST_WR;
                    end
                end else begin
                    hold_req = 1'b1;
                    mem_en   = 1'b1;
                    d.have   = 1'b0;
                    d.st     = ST_WR;
                end
            end
            ST_WR: begin
                mem_addr = dst_sel;
                if (q.mode == MODE_TRANS) begin
                    if (cpu_idle) begin
                        mem_en = 1'b1;
                        mem_we = 1'b1;
                        step   = 1'b1;
                        d.have = 1'b0;
                        d.st   = ST_IDLE;
                    end else if (!q.have) begin
                        d.data = mem_rdata;
                        d.have = 1'b1;
                    end
                end else begin
                    hold_req = 1'b1;
                    mem_en   = 1'b1;
                    mem_we   = 1'b1;
                    step     = 1'b1;
                    d.have   = 1'b0;
                    d.run    = q.run + 1'b1;
                    if (q.mode == MODE_STEAL || last_sel || q.run == RUN_LAST || !avail_sel)
                        d.st = ST_REL;
                    else
                        d.st = ST_RD;
                end
            end
            ST_REL: begin
                if (!hold_ack) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.mode <= MODE_BURST;
        end else begin
            q <= d;
        end
    end

    assign cur_ch = q.ch;

    AST_TRANS_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE && q.mode == MODE_TRANS) |-> !hold_req) else $error("hold in transparent"); // R7

    AST_TRANS_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && q.mode == MODE_TRANS) |-> cpu_idle) else $error("bus used while cpu busy"); // R7

    AST_BUS_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && q.mode != MODE_TRANS) |-> hold_ack) else $error("bus used without grant"); // R9

    AST_STEAL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && q.mode == MODE_STEAL) |=> !hold_req) else $error("steal kept bus"); // R6

    AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        q.run <= RW'(RUN_MAX)) else $error("burst run too long"); // R4

endmodule

// File: rtl/mdma_engine.sv
`timescale 1ns/1ps
module mdma_engine
    import mdma_pkg::*;
#(
    parameter  int NCH     = 4,
    parameter  int AW      = 16,
    parameter  int CW      = 24,
    parameter  int RUN_MAX = 32,
    localparam int CHW     = $clog2(NCH),
    localparam int DW      = (AW > CW) ? AW : CW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [CHW-1:0] cfg_chan,
    input  logic [1:0]     cfg_field,
    input  logic [DW-1:0]  cfg_wdata,
    input  logic [1:0]     xfer_mode,
    output logic           hold_req,
    input  logic           hold_ack,
    input  logic           cpu_idle,
    output logic           mem_en,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [7:0]     mem_wdata,
    input  logic [7:0]     mem_rdata,
    input  logic [NCH-1:0] src_avail,
    input  logic [NCH-1:0] dst_space,
    output logic [NCH-1:0] done
);

    logic [AW-1:0]  src_a [NCH];
    logic [AW-1:0]  dst_a [NCH];
    logic [CW-1:0]  cnt_a [NCH];
    logic [NCH-1:0] pend;
    logic [NCH-1:0] ready;
    logic           cand_any;
    logic [CHW-1:0] cand_idx;
    logic [CHW-1:0] cur_ch;
    logic           mv_step;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        mdma_chan #(.AW(AW), .CW(CW), .DW(DW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (cfg_we && cfg_chan == CHW'(g)),
            .wr_field (cfg_field),
            .wr_data  (cfg_wdata),
            .step     (mv_step && cur_ch == CHW'(g)),
            .src_addr (src_a[g]),
            .dst_addr (dst_a[g]),
            .count    (cnt_a[g]),
            .pending  (pend[g]),
            .done     (done[g])
        );
    end

    assign ready = pend & src_avail & dst_space;

    mdma_prio #(.N(NCH)) u_prio (
        .req (ready),
        .any (cand_any),
        .idx (cand_idx)
    );

    mdma_mover #(.NCH(NCH), .AW(AW), .RUN_MAX(RUN_MAX)) u_mover (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (xfer_mode_e'(xfer_mode)),
        .cand_any  (cand_any),
        .cand_idx  (cand_idx),
        .src_sel   (src_a[cur_ch]),
        .dst_sel   (dst_a[cur_ch]),
        .last_sel  (cnt_a[cur_ch] == CW'(1)),
        .avail_sel (src_avail[cur_ch] && dst_space[cur_ch]),
        .hold_ack  (hold_ack),
        .cpu_idle  (cpu_idle),
        .mem_rdata (mem_rdata),
        .hold_req  (hold_req),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .step      (mv_step),
        .cur_ch    (cur_ch)
    );

endmodule

// File: tb/mdma_engine_test.sv
`timescale 1ns/1ps
module mdma_engine_test;

    localparam int NCH = 4;
    localparam int AW  = 16;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic           rst_n = 1'b0;
    logic           cfg_we = 1'b0;
    logic [1:0]     cfg_chan = '0;
    logic [1:0]     cfg_field = '0;
    logic [23:0]    cfg_wdata = '0;
    logic [1:0]     xfer_mode = 2'd0;
    logic           hold_req;
    logic           hold_ack = 1'b0;
    logic           cpu_idle = 1'b1;
    logic           mem_en, mem_we;
    logic [AW-1:0]  mem_addr;
    logic [7:0]     mem_wdata;
    logic [7:0]     mem_rdata = '0;
    logic [NCH-1:0] src_base = '1;
    logic [NCH-1:0] dst_space = '1;
    logic [NCH-1:0] src_avail;
    logic [NCH-1:0] done;

    bit   idle_rand = 1'b0;
    bit   avail_rand = 1'b0;
    logic av_bit = 1'b1;

    assign src_avail = {src_base[NCH-1:1], src_base[0] & (avail_rand ? av_bit : 1'b1)};

    mdma_engine uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .xfer_mode(xfer_mode),
        .hold_req(hold_req), .hold_ack(hold_ack), .cpu_idle(cpu_idle),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .src_avail(src_avail),
        .dst_space(dst_space), .done(done)
    );

    logic [7:0] mem [0:4095];
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[11:0]];
        end
    end

    // CPU model: grants after a random delay, releases once the request falls
    always @(negedge clk) begin
        if (!rst_n) hold_ack <= 1'b0;
        else        hold_ack <= hold_req && (hold_ack || ($urandom % 2 == 1));
        cpu_idle <= idle_rand ? ($urandom % 3 != 0) : 1'b1;
        av_bit   <= ($urandom % 4 != 0);
    end

    // bus monitor
    int   grants, cur_wr, max_wr, hold_seen, idle_viol, own_viol;
    logic [AW-1:0] first_wr;
    bit   got_first, mon_clr, prev_req;
    always @(posedge clk) begin
        if (mon_clr) begin
            grants = 0; cur_wr = 0; max_wr = 0; hold_seen = 0;
            idle_viol = 0; own_viol = 0; got_first = 0; first_wr = '0;
        end else if (rst_n) begin
            if (hold_req) hold_seen++;
            if (hold_req && !prev_req) begin grants++; cur_wr = 0; end
            if (mem_en && xfer_mode == 2'd2 && !cpu_idle) idle_viol++;
            if (mem_en && xfer_mode != 2'd2 && !hold_ack) own_viol++;
            if (mem_en && mem_we) begin
                if (!got_first) first_wr = mem_addr;
                got_first = 1;
                if (hold_req) begin
                    cur_wr++;
                    if (cur_wr > max_wr) max_wr = cur_wr;
                end
            end
        end
        prev_req = hold_req;
    end

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cfg(int ch, int f, int v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_chan = 2'(ch); cfg_field = 2'(f); cfg_wdata = 24'(v);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic prog(int ch, int s, int d, int n);
        cfg(ch, 0, s);
        cfg(ch, 1, d);
        cfg(ch, 2, n);
        cfg(ch, 3, 1);
    endtask

    task automatic mon_reset();
        @(negedge clk); mon_clr = 1'b1;
        @(negedge clk); mon_clr = 1'b0;
    endtask

    task automatic wait_done(int ch, string tag);
        int t = 0;
        while (!done[ch] && t < 5000) begin @(negedge clk); t++; end
        chk(done[ch] == 1'b1, tag, int'(done[ch]), 1);
    endtask

    function automatic int mism(int s, int d, int n);
        int m = 0;
        for (int k = 0; k < n; k++)
            if (mem[(d + k) % 4096] !== mem[(s + k) % 4096]) m++;
        return m;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk(done == '0, "R2 reset done", int'(done), 0);
        chk(hold_req == 1'b0, "R2 reset hold", int'(hold_req), 0);
        chk(mem_en == 1'b0, "R1 reset mem", int'(mem_en), 0);

        // burst, 40 bytes, flow control open
        xfer_mode = 2'd0;
        mon_reset();
        prog(0, 12'h000, 12'h400, 40);
        wait_done(0, "R2 burst done");
        chk(mism(12'h000, 12'h400, 40) == 0, "R1 burst data", mism(12'h000, 12'h400, 40), 0);
        chk(grants == 2, "R4 burst grants", grants, 2);
        chk(max_wr == 32, "R4 burst run length", max_wr, 32);
        chk(own_viol == 0, "R9 bus ownership", own_viol, 0);
        repeat (10) @(negedge clk);
        chk(done[0] == 1'b1, "R2 done sticky", int'(done[0]), 1);
        chk(hold_seen == 3 * 0 + hold_seen && !hold_req, "R2 no request after finish", int'(hold_req), 0);
        cfg(0, 3, 2);
        chk(done[0] == 1'b0, "R10 clear done", int'(done[0]), 0);

        // stealing, 5 bytes
        xfer_mode = 2'd1;
        mon_reset();
        prog(2, 12'h050, 12'h480, 5);
        wait_done(2, "R11 steal done");
        chk(grants == 5, "R6 steal grants", grants, 5);
        chk(max_wr == 1, "R6 steal one per grant", max_wr, 1);
        chk(mism(12'h050, 12'h480, 5) == 0, "R1 steal data", mism(12'h050, 12'h480, 5), 0);
        cfg(2, 3, 2);

        // transparent with random CPU activity
        xfer_mode = 2'd2;
        idle_rand = 1'b1;
        mon_reset();
        prog(3, 12'h090, 12'h500, 20);
        wait_done(3, "R7 transparent done");
        chk(hold_seen == 0, "R7 no hold request", hold_seen, 0);
        chk(idle_viol == 0, "R7 idle cycles only", idle_viol, 0);
        chk(mism(12'h090, 12'h500, 20) == 0, "R1 transparent data", mism(12'h090, 12'h500, 20), 0);
        idle_rand = 1'b0;
        cfg(3, 3, 2);

        // zero count start
        xfer_mode = 2'd0;
        mon_reset();
        cfg(1, 2, 0);
        cfg(1, 3, 1);
        chk(done[1] == 1'b1, "R3 zero count done", int'(done[1]), 1);
        repeat (5) @(negedge clk);
        chk(hold_seen == 0, "R3 zero count no request", hold_seen, 0);
        cfg(1, 3, 2);

        // priority: channels 0 and 1 released together
        xfer_mode = 2'd1;
        src_base[1:0] = 2'b00;
        prog(1, 12'h140, 12'hB00, 4);
        prog(0, 12'h100, 12'hA00, 4);
        mon_reset();
        src_base[1:0] = 2'b11;
        wait_done(0, "R8 ch0 done");
        wait_done(1, "R8 ch1 done");
        chk(first_wr == 16'h0A00, "R8 lower index first", int'(first_wr), 16'h0A00);
        chk(mism(12'h140, 12'hB00, 4) == 0, "R1 ch1 data", mism(12'h140, 12'hB00, 4), 0);
        cfg(0, 3, 2);
        cfg(1, 3, 2);

        // burst with source availability toggling
        xfer_mode = 2'd0;
        avail_rand = 1'b1;
        mon_reset();
        prog(0, 12'h200, 12'hC00, 24);
        wait_done(0, "R5 interrupted burst done");
        avail_rand = 1'b0;
        chk(mism(12'h200, 12'hC00, 24) == 0, "R5 resumed data", mism(12'h200, 12'hC00, 24), 0);
        chk(grants >= 2, "R5 early run end", grants, 2);
        chk(own_viol == 0, "R9 bus ownership toggled", own_viol, 0);
        cfg(0, 3, 2);

        // random mix
        for (int it = 0; it < 8; it++) begin
            int ch = $urandom % 4;
            int md = $urandom % 3;
            int n  = 1 + $urandom % 50;
            int s  = $urandom % 1024;
            int d  = 12'hD00 + (it % 4) * 64;
            xfer_mode = 2'(md);
            idle_rand = (md == 2);
            mon_reset();
            prog(ch, s, d, n);
            wait_done(ch, "R2 random done");
            chk(mism(s, d, n) == 0, "R1 random data", mism(s, d, n), 0);
            if (md == 0) chk(max_wr <= 32, "R4 random run", max_wr, 32);
            if (md == 1) chk(grants == n, "R6 random steal grants", grants, n);
            if (md == 2) chk(hold_seen == 0 && idle_viol == 0, "R7 random transparent", hold_seen + idle_viol, 0);
            chk(own_viol == 0, "R9 random ownership", own_viol, 0);
            idle_rand = 1'b0;
            cfg(ch, 3, 2);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule